// File: doc/BRIEF.md
# Delay-Slot Program Sequencer

This block keeps the program counter of a small command-processing microcontroller. Each cycle with `step_i` high retires one instruction: decode supplies the operation class and its fields, the register file supplies operand values, and the sequencer decides the next PC. Every control transfer (conditional branch, call, return, branch-and-link, return through the link register, jump through a register) has exactly one delay slot. The instruction after the transfer still executes, and only then does the PC move to the target.

Calls push a return address two words ahead onto a small internal hardware stack, and returns pop it. An instruction carrying the repeat flag is re-issued in place while the remaining-count register is nonzero, and the count drops by one on each pass. A wait instruction arms a packet dispatch. Once its delay slot retires, the command header presented on `hdr_i` is classified. Its handler id addresses an external jump table through a combinational read port, the PC is loaded from that table, and the remaining count is loaded from the header's length field.

Top module: `dslot_seq`

## Requirements
- R1: After reset, `pc_o`, `rem_o` and `sp_o` are 0, and no transfer or dispatch is pending.
- R2: A step with no transfer pending moves `pc_o` to PC+1 on the next clock edge. A cycle with `step_i` low leaves the PC unchanged.
- R3: Conditional branches have a target of PC + `offset_i` (two's complement). The taken condition depends on `op_i`: code 1 when `src_i` != `imm_i`, code 2 when they are equal, code 3 when bit `bit_sel_i` of `src_i` is 0, code 4 when that bit is 1. A taken branch moves the PC to PC+1 first, and the target is loaded when the next instruction retires.
- R4: A call (code 5) pushes PC+2, increments `sp_o` and branches to `literal_i`. A return (code 6) branches to the most recently pushed address and decrements `sp_o`. Both take effect after one delay slot.
- R5: Branch-and-link (code 7) pulses `lr_we_o` with `lr_wdata_o` = PC+2 and branches to `literal_i`. Code 8 branches to `lr_i`. Code 9 branches to `gpr_i`. All three have one delay slot.
- R6: With `rep_i` set on a code-0 instruction and `rem_o` nonzero, the instruction executes (`exec_o`=1), `rem_o` decrements, and the PC holds until `rem_o` reaches 0. With `rem_o` already 0, it does not execute (`exec_o`=0) and the PC advances.
- R7: When `word_hi_i` (the top five bits of the instruction word) is 0, the instruction is a NOP: `op_i` and `rep_i` are ignored.
- R8: A wait (code 10) arms a dispatch that fires when the following instruction retires. A header with bits [31:28] = 4 pulses `r1_we_o` with the header's bits [31:28] cleared, drives `jt_addr_o` = `PKT4_ID`, and loads `rem_o` from bits [6:0] and the PC from `jt_data_i`.
- R9: A header with bits [31:28] = 7 drives `jt_addr_o` from bits [22:16], loads `rem_o` from bits [13:0] and the PC from `jt_data_i`, and does not write r1.
- R10: A header with any other top nibble pulses `bad_pkt_o` in the dispatch cycle. The PC then advances to PC+1, and `rem_o` is unchanged.
- R11: A call with `sp_o` = `DEPTH` pulses `err_ovf_o`, drops the push, leaves `sp_o` unchanged, and still branches. A return with `sp_o` = 0 pulses `err_udf_o` and causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | An instruction retires this cycle |
| op_i | input | 4 | Operation class code |
| rep_i | input | 1 | Repeat flag of the instruction |
| word_hi_i | input | 5 | Top five bits of the raw instruction word |
| src_i | input | DATA_W | Source register value for compares |
| imm_i | input | DATA_W | Immediate for compare branches |
| bit_sel_i | input | $clog2(DATA_W) | Bit index for bit-test branches |
| offset_i | input | PC_W | Signed branch offset |
| literal_i | input | PC_W | Absolute target for call and branch-and-link |
| gpr_i | input | PC_W | Register value for register jump |
| lr_i | input | PC_W | Current link register value |
| hdr_i | input | 32 | Command header (r1) at dispatch |
| jt_data_i | input | PC_W | Jump table entry for `jt_addr_o` |
| pc_o | output | PC_W | Program counter |
| rem_o | output | REM_W | Remaining-count register |
| sp_o | output | $clog2(DEPTH+1) | Call stack depth |
| exec_o | output | 1 | The stepped instruction takes effect |
| lr_we_o | output | 1 | Link register write strobe |
| lr_wdata_o | output | PC_W | Link register write value |
| r1_we_o | output | 1 | Header register write strobe |
| r1_wdata_o | output | 32 | Header with type nibble cleared |
| jt_addr_o | output | 7 | Jump table read index |
| err_ovf_o | output | 1 | Call on a full stack |
| err_udf_o | output | 1 | Return on an empty stack |
| bad_pkt_o | output | 1 | Unrecognised header at dispatch |

## Verification
The embedded properties watch, on every cycle, that a consumed pending target lands in the PC and that a repeat pass lowers the count by exactly one. They also check that the stack never exceeds its depth, that the entry written by a call holds PC+2, that an underflowing return leaves the depth at zero, and that an invalid header leaves the count alone. Only the directed scenarios show the full delay-slot ordering for each transfer kind, the classification of both header types, and the table lookup. The same holds for the overflow and NOP cases and the hold-then-release timing of a repeat run, since those depend on multi-instruction sequences with known addresses.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int OP_W = 4;
  localparam int ID_W = 7;
  localparam int HDR_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_ALU    = 4'd0,
    OP_BNE_IM = 4'd1,
    OP_BEQ_IM = 4'd2,
    OP_BCLR   = 4'd3,
    OP_BSET   = 4'd4,
    OP_CALL   = 4'd5,
    OP_RET    = 4'd6,
    OP_BLINK  = 4'd7,
    OP_RETLR  = 4'd8,
    OP_JREG   = 4'd9,
    OP_WAIT   = 4'd10
  } op_e;
endpackage

// File: rtl/dslot_cond.sv
module dslot_cond
  import dslot_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 32,
  localparam int BS_W  = $clog2(DATA_W)
) (
  input  op_e              op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [BS_W-1:0]  bit_sel_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  offset_i,
  input  logic [PC_W-1:0]  literal_i,
  input  logic [PC_W-1:0]  gpr_i,
  input  logic [PC_W-1:0]  lr_i,
  input  logic [PC_W-1:0]  stk_top_i,
  input  logic             stk_empty_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  tgt_o
);
  logic [PC_W-1:0] rel_tgt;
  logic            sel_bit;

  assign rel_tgt = pc_i + offset_i;
  assign sel_bit = src_i[bit_sel_i];

  always_comb begin
    taken_o = 1'b0;
    tgt_o   = rel_tgt;
    unique case (op_i)
      OP_BNE_IM: taken_o = (src_i != imm_i);
      OP_BEQ_IM: taken_o = (src_i == imm_i);
      OP_BCLR:   taken_o = ~sel_bit;
      OP_BSET:   taken_o = sel_bit;
      OP_CALL:   begin taken_o = 1'b1;         tgt_o = literal_i; end
      OP_RET:    begin taken_o = ~stk_empty_i; tgt_o = stk_top_i; end
      OP_BLINK:  begin taken_o = 1'b1;         tgt_o = literal_i; end
      OP_RETLR:  begin taken_o = 1'b1;         tgt_o = lr_i;      end
      OP_JREG:   begin taken_o = 1'b1;         tgt_o = gpr_i;     end
      default:   taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dslot_stack.sv
module dslot_stack #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic [PC_W-1:0] top_o,
  output logic [SP_W-1:0] sp_o,
  output logic            full_o,
  output logic            empty_o
);
  logic [PC_W-1:0] ent_q [DEPTH];
  logic [SP_W-1:0] sp_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[g] <= '0;
      else if (push_i && sp_q == SP_W'(g))      ent_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (push_i)  sp_q <= sp_q + SP_W'(1);
    else if (pop_i)   sp_q <= sp_q - SP_W'(1);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_o = ent_q[i];
  end

  assign sp_o    = sp_q;
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);

  // R4: depth never exceeds capacity
  a_r4_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH));
  // R11: caller never pushes into a full stack
  a_r11_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R11: caller never pops an empty stack
  a_r11_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/dslot_disp.sv
module dslot_disp
  import dslot_pkg::*;
#(
  parameter int REM_W = 14,
  parameter logic [ID_W-1:0] PKT4_ID = 7'h10
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic             is4_o,
  output logic             is7_o,
  output logic [ID_W-1:0]  id_o,
  output logic [REM_W-1:0] count_o,
  output logic [HDR_W-1:0] r1_clean_o
);
  assign is4_o      = (hdr_i[31:28] == 4'h4);
  assign is7_o      = (hdr_i[31:28] == 4'h7);
  assign id_o       = is4_o ? PKT4_ID : hdr_i[22:16];
  assign count_o    = is4_o ? REM_W'(hdr_i[6:0]) : REM_W'(hdr_i[13:0]);
  assign r1_clean_o = {4'h0, hdr_i[27:0]};
endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
  import dslot_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int REM_W  = 14,
  parameter logic [6:0] PKT4_ID = 7'h10,
  localparam int BS_W  = $clog2(DATA_W),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [3:0]        op_i,
  input  logic              rep_i,
  input  logic [4:0]        word_hi_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [BS_W-1:0]   bit_sel_i,
  input  logic [PC_W-1:0]   offset_i,
  input  logic [PC_W-1:0]   literal_i,
  input  logic [PC_W-1:0]   gpr_i,
  input  logic [PC_W-1:0]   lr_i,
  input  logic [31:0]       hdr_i,
  input  logic [PC_W-1:0]   jt_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [REM_W-1:0]  rem_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              exec_o,
  output logic              lr_we_o,
  output logic [PC_W-1:0]   lr_wdata_o,
  output logic              r1_we_o,
  output logic [31:0]       r1_wdata_o,
  output logic [6:0]        jt_addr_o,
  output logic              err_ovf_o,
  output logic              err_udf_o,
  output logic              bad_pkt_o
);
  logic [PC_W-1:0]  pc_q, pend_t_q, pc_plus2, tgt, stk_top;
  logic [REM_W-1:0] rem_q, disp_count;
  logic             pend_v_q, wait_q;
  logic             is_nop, rep_eff, rem_zero, hold, advance, taken;
  logic             stk_full, stk_empty, push, pop;
  logic             disp, disp_ok, is4, is7;
  logic [SP_W-1:0]  sp;
  op_e              op;

  assign is_nop   = (word_hi_i == 5'd0);
  assign op       = is_nop ? OP_ALU : op_e'(op_i);
  assign rep_eff  = rep_i && !is_nop && (op == OP_ALU);
  assign rem_zero = (rem_q == '0);
  // a repeat pass that leaves count nonzero re-issues in place
  assign hold     = step_i && rep_eff && (rem_q > REM_W'(1));
  assign advance  = step_i && !hold;
  assign pc_plus2 = pc_q + PC_W'(2);

  dslot_cond #(.PC_W(PC_W), .DATA_W(DATA_W)) u_cond (
    .op_i(op), .src_i(src_i), .imm_i(imm_i), .bit_sel_i(bit_sel_i),
    .pc_i(pc_q), .offset_i(offset_i), .literal_i(literal_i),
    .gpr_i(gpr_i), .lr_i(lr_i), .stk_top_i(stk_top),
    .stk_empty_i(stk_empty), .taken_o(taken), .tgt_o(tgt)
  );

  assign push = advance && (op == OP_CALL) && !stk_full;
  assign pop  = advance && (op == OP_RET) && !stk_empty;

  dslot_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(pc_plus2), .top_o(stk_top), .sp_o(sp),
    .full_o(stk_full), .empty_o(stk_empty)
  );

  dslot_disp #(.REM_W(REM_W), .PKT4_ID(PKT4_ID)) u_disp (
    .hdr_i(hdr_i), .is4_o(is4), .is7_o(is7), .id_o(jt_addr_o),
    .count_o(disp_count), .r1_clean_o(r1_wdata_o)
  );

  assign disp    = advance && wait_q;
  assign disp_ok = disp && (is4 || is7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      pend_v_q <= 1'b0;
      pend_t_q <= '0;
      wait_q   <= 1'b0;
    end else if (advance) begin
      pend_v_q <= taken;
      pend_t_q <= tgt;
      wait_q   <= (op == OP_WAIT);
      if (disp_ok)       pc_q <= jt_data_i;
      else if (pend_v_q) pc_q <= pend_t_q;
      else               pc_q <= pc_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rem_q <= '0;
    else if (disp_ok)                           rem_q <= disp_count;
    else if (step_i && rep_eff && !rem_zero)    rem_q <= rem_q - REM_W'(1);
  end

  assign pc_o       = pc_q;
  assign rem_o      = rem_q;
  assign sp_o       = sp;
  assign exec_o     = step_i && !(rep_eff && rem_zero);
  assign lr_we_o    = advance && (op == OP_BLINK);
  assign lr_wdata_o = pc_plus2;
  assign r1_we_o    = disp && is4;
  assign err_ovf_o  = advance && (op == OP_CALL) && stk_full;
  assign err_udf_o  = advance && (op == OP_RET) && stk_empty;
  assign bad_pkt_o  = disp && !(is4 || is7);

  // R3: a consumed pending target lands in the PC
  a_r3_slot_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && pend_v_q && !wait_q) |=> pc_q == $past(pend_t_q));
  // R6: every repeat pass lowers the count by one
  a_r6_rem_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && rep_eff && !rem_zero && !wait_q) |=> rem_q == $past(rem_q) - REM_W'(1));
  // R4: the stack entry written by a call holds PC+2
  a_r4_push_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> stk_top == $past(pc_q) + PC_W'(2));
  // R11: an underflowing return leaves the stack empty
  a_r11_udf_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_udf_o |=> sp_o == '0);
  // R10: an invalid header leaves the count alone
  a_r10_bad_keeps_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_pkt_o && !rep_eff) |=> $stable(rem_q));
  // R8: header write and error never coincide
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({r1_we_o, bad_pkt_o}));
endmodule

// File: tb/tb_dslot_seq.sv
module tb_dslot_seq;
  import dslot_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic step_i = 1'b0, rep_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [4:0]  word_hi_i = 5'h1f;
  logic [31:0] src_i = '0, imm_i = '0, hdr_i = '0;
  logic [4:0]  bit_sel_i = '0;
  logic [11:0] offset_i = '0, literal_i = '0, gpr_i = '0, lr_i = '0;
  logic [11:0] jt_data_i, pc_o, lr_wdata_o;
  logic [13:0] rem_o;
  logic [2:0]  sp_o;
  logic        exec_o, lr_we_o, r1_we_o, err_ovf_o, err_udf_o, bad_pkt_o;
  logic [31:0] r1_wdata_o;
  logic [6:0]  jt_addr_o;

  int checks = 0, errors = 0;
  logic c_exec, c_lrwe, c_r1we, c_ovf, c_udf, c_bad;
  logic [11:0] c_lrd;
  logic [31:0] c_r1d;
  logic [6:0]  c_jt;

  always #10 clk = ~clk;
  assign jt_data_i = 12'h100 + {5'b0, jt_addr_o};

  dslot_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .op_i(op_i), .rep_i(rep_i),
    .word_hi_i(word_hi_i), .src_i(src_i), .imm_i(imm_i), .bit_sel_i(bit_sel_i),
    .offset_i(offset_i), .literal_i(literal_i), .gpr_i(gpr_i), .lr_i(lr_i),
    .hdr_i(hdr_i), .jt_data_i(jt_data_i), .pc_o(pc_o), .rem_o(rem_o),
    .sp_o(sp_o), .exec_o(exec_o), .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o),
    .r1_we_o(r1_we_o), .r1_wdata_o(r1_wdata_o), .jt_addr_o(jt_addr_o),
    .err_ovf_o(err_ovf_o), .err_udf_o(err_udf_o), .bad_pkt_o(bad_pkt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    op_i = OP_ALU; rep_i = 1'b0; word_hi_i = 5'h1f; src_i = '0; imm_i = '0;
    bit_sel_i = '0; offset_i = '0; literal_i = '0; gpr_i = '0; lr_i = '0; hdr_i = '0;
  endtask

  task automatic go();
    step_i = 1'b1;
    #2;
    c_exec = exec_o; c_lrwe = lr_we_o; c_lrd = lr_wdata_o; c_r1we = r1_we_o;
    c_r1d = r1_wdata_o; c_jt = jt_addr_o; c_ovf = err_ovf_o; c_udf = err_udf_o;
    c_bad = bad_pkt_o;
    @(posedge clk); @(negedge clk);
    step_i = 1'b0;
    clr();
  endtask

  task automatic do_rst();
    clr(); step_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_rst();
    chk("R1 pc", pc_o, 0); chk("R1 rem", rem_o, 0); chk("R1 sp", sp_o, 0);
    go(); chk("R2 pc+1", pc_o, 1);
    @(negedge clk); chk("R2 idle hold", pc_o, 1);
  endtask

  task automatic t_branch();
    op_i = OP_BNE_IM; src_i = 5; imm_i = 3; offset_i = 12'd10; go();
    chk("R3 bne slot", pc_o, 2);
    go(); chk("R3 bne target", pc_o, 11);
    op_i = OP_BEQ_IM; src_i = 5; imm_i = 5; offset_i = 12'hffc; go();
    chk("R3 beq slot", pc_o, 12);
    go(); chk("R3 beq back", pc_o, 7);
    op_i = OP_BEQ_IM; src_i = 1; imm_i = 2; offset_i = 12'd20; go(); go();
    chk("R3 beq not taken", pc_o, 9);
    op_i = OP_BSET; src_i = 8; bit_sel_i = 3; offset_i = 12'd4; go(); go();
    chk("R3 bset target", pc_o, 13);
    op_i = OP_BCLR; src_i = 1; bit_sel_i = 0; offset_i = 12'd4; go(); go();
    chk("R3 bclr not taken", pc_o, 15);
    op_i = OP_BCLR; src_i = 1; bit_sel_i = 1; offset_i = 12'd2; go(); go();
    chk("R3 bclr target", pc_o, 17);
  endtask

  task automatic t_call();
    do_rst();
    op_i = OP_CALL; literal_i = 12'd100; go();
    chk("R4 call slot", pc_o, 1); chk("R4 sp 1", sp_o, 1);
    go(); chk("R4 call target", pc_o, 100);
    op_i = OP_CALL; literal_i = 12'd200; go(); go();
    chk("R4 nested", pc_o, 200); chk("R4 sp 2", sp_o, 2);
    op_i = OP_RET; go(); chk("R4 ret slot", pc_o, 201); chk("R4 sp pop", sp_o, 1);
    go(); chk("R4 ret target", pc_o, 102);
    op_i = OP_RET; go(); go(); chk("R4 ret outer", pc_o, 2);
    op_i = OP_RET; go(); chk("R11 udf flag", c_udf, 1); chk("R11 udf sp", sp_o, 0);
    go(); chk("R11 udf no transfer", pc_o, 4);
  endtask

  task automatic t_over();
    do_rst();
    for (int k = 0; k < 4; k++) begin
      op_i = OP_CALL; literal_i = 12'(40 + 10 * k); go(); go();
    end
    chk("R4 fill sp", sp_o, 4); chk("R4 fill pc", pc_o, 70);
    op_i = OP_CALL; literal_i = 12'd80; go();
    chk("R11 ovf flag", c_ovf, 1); chk("R11 ovf sp", sp_o, 4);
    go(); chk("R11 ovf still branches", pc_o, 80);
    op_i = OP_RET; go(); go();
    chk("R11 top kept", pc_o, 62); chk("R11 sp after pop", sp_o, 3);
  endtask

  task automatic t_link();
    do_rst();
    op_i = OP_BLINK; literal_i = 12'd30; go();
    chk("R5 lr we", c_lrwe, 1); chk("R5 lr data", c_lrd, 2);
    go(); chk("R5 bl target", pc_o, 30);
    op_i = OP_RETLR; lr_i = 12'd7; go(); chk("R5 retlr slot", pc_o, 31);
    go(); chk("R5 retlr target", pc_o, 7);
    op_i = OP_JREG; gpr_i = 12'd55; go(); go();
    chk("R5 jreg target", pc_o, 55);
  endtask

  task automatic t_wait_rep();
    do_rst();
    op_i = OP_WAIT; go(); chk("R8 wait slot pc", pc_o, 1);
    hdr_i = 32'h4567_0003; go();
    chk("R8 r1 we", c_r1we, 1); chk("R8 r1 data", c_r1d, 32'h0567_0003);
    chk("R8 jt id", c_jt, 7'h10); chk("R8 pc", pc_o, 12'h110); chk("R8 rem", rem_o, 3);
    rep_i = 1'b1; go(); chk("R6 exec", c_exec, 1);
    chk("R6 hold pc", pc_o, 12'h110); chk("R6 rem 2", rem_o, 2);
    rep_i = 1'b1; go(); chk("R6 rem 1", rem_o, 1); chk("R6 still held", pc_o, 12'h110);
    rep_i = 1'b1; go(); chk("R6 rem 0", rem_o, 0); chk("R6 release", pc_o, 12'h111);
    rep_i = 1'b1; go(); chk("R6 no exec at 0", c_exec, 0);
    chk("R6 advance at 0", pc_o, 12'h112); chk("R6 rem stays", rem_o, 0);
  endtask

  task automatic t_wait7_bad_nop();
    op_i = OP_WAIT; go();
    hdr_i = 32'h7025_0105; go();
    chk("R9 no r1 write", c_r1we, 0); chk("R9 jt id", c_jt, 7'h25);
    chk("R9 pc", pc_o, 12'h125); chk("R9 rem", rem_o, 14'h105);
    op_i = OP_WAIT; go();
    hdr_i = 32'h2000_0000; go();
    chk("R10 bad flag", c_bad, 1); chk("R10 pc", pc_o, 12'h127);
    chk("R10 rem kept", rem_o, 14'h105);
    word_hi_i = 5'd0; op_i = OP_BEQ_IM; rep_i = 1'b1; offset_i = 12'd20; go();
    chk("R7 nop pc", pc_o, 12'h128); chk("R7 rep ignored", rem_o, 14'h105);
    go(); chk("R7 no branch", pc_o, 12'h129);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    t_reset();
    t_branch();
    t_call();
    t_over();
    t_link();
    t_wait_rep();
    t_wait7_bad_nop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule